// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block produces the two port-to-port doorbell flags that sit beside a shared two-port memory. It has no storage of its own for message data. It watches the enable, direction, output-enable and address lines of both ports. It treats the two highest word addresses of the memory as mailboxes. Each port posts into one of them and collects from the other.

Posting means writing to the mailbox. When the left port writes its outgoing mailbox (the highest address), the right port's flag is pulled low. When the right port writes its outgoing mailbox (the address just below), the left port's flag is pulled low. A port acknowledges the message by reading the mailbox addressed to it, and that read releases its own flag.

Flags live in registers. They change on the clock edge that samples the access, and they hold their value between events. Port control lines are active low. A write is `*_wr_n` low. A read is `*_wr_n` high together with `*_oe_n` low.

Top module: `mbx_irq_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, both `a_irq_n` and `b_irq_n` are high.
- R2: A left-port write (`a_sel_n`=0, `a_wr_n`=0) to address 2^ADDR_W-1 (0x3FF by default) drives `b_irq_n` low after the next rising clock edge.
- R3: A right-port read (`b_sel_n`=0, `b_wr_n`=1, `b_oe_n`=0) of address 2^ADDR_W-1 returns `b_irq_n` high after the next edge, unless a set for that flag happens in the same cycle.
- R4: A right-port write (`b_sel_n`=0, `b_wr_n`=0) to address 2^ADDR_W-2 (0x3FE by default) drives `a_irq_n` low after the next edge.
- R5: A left-port read (`a_sel_n`=0, `a_wr_n`=1, `a_oe_n`=0) of address 2^ADDR_W-2 returns `a_irq_n` high after the next edge, unless a set for that flag happens in the same cycle.
- R6: A port's enable gates both kinds of event. A read with the output enable high does not clear a flag. A write with the enable high does not set one.
- R7: When a set and a clear of the same flag happen in the same cycle, the flag ends low (with the default SET_WINS=1).
- R8: Accesses that do not match R2 to R5 leave both flags unchanged. This covers other addresses, a port writing the mailbox addressed to itself, and a port reading its own outgoing mailbox.
- R9: Once a flag is low, it stays low through idle cycles and through repeated posts until a qualifying read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_sel_n | input | 1 | Left port enable, active low |
| a_wr_n | input | 1 | Left port direction: 0 write, 1 read |
| a_oe_n | input | 1 | Left port output enable, active low |
| a_addr | input | ADDR_W | Left port word address |
| b_sel_n | input | 1 | Right port enable, active low |
| b_wr_n | input | 1 | Right port direction: 0 write, 1 read |
| b_oe_n | input | 1 | Right port output enable, active low |
| b_addr | input | ADDR_W | Right port word address |
| a_irq_n | output | 1 | Flag to the left port, active low |
| b_irq_n | output | 1 | Flag to the right port, active low |

## Verification
The main function is driven in both directions separately, so a swap of the two mailbox addresses or of the two flags shows up as the wrong port reacting. Near-miss accesses are applied to each mailbox:
- a write with the enable high;
- a read with the output enable high;
- a write to the port's own incoming mailbox;
- an access one address below.

Each of these separates a full decode from a partial one. A simultaneous post and collect on the same mailbox distinguishes set-priority from clear-priority. Repeated posts and idle cycles distinguish a held flag from a pulse.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   localparam int NUM_PORTS = 2;

   // Control lines of one port, all active low
   typedef struct packed {
      logic sel_n;
      logic wr_n;
      logic oe_n;
   } port_ctl_t;

   function automatic logic is_write(port_ctl_t c);
      return !c.sel_n && !c.wr_n;
   endfunction

   function automatic logic is_read(port_ctl_t c);
      return !c.sel_n && c.wr_n && !c.oe_n;
   endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
   import mbx_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter logic [ADDR_W-1:0] OUT_ADDR = '1,
   parameter logic [ADDR_W-1:0] IN_ADDR  = '0
) (
   input  port_ctl_t         ctl,
   input  logic [ADDR_W-1:0] addr,
   output logic              post,
   output logic              fetch
);

   logic hit_out;
   logic hit_in;

   assign hit_out = (addr == OUT_ADDR);
   assign hit_in  = (addr == IN_ADDR);

   always_comb begin
      post  = is_write(ctl) && hit_out;
      fetch = is_read(ctl) && hit_in;
   end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag_n
);

   logic nxt_n;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb begin
            nxt_n = flag_n;
            if (set)      nxt_n = 1'b0;
            else if (clr) nxt_n = 1'b1;
         end
      end else begin : g_clr_first
         always_comb begin
            nxt_n = flag_n;
            if (clr)      nxt_n = 1'b1;
            else if (set) nxt_n = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_n <= 1'b1;
      else        flag_n <= nxt_n;
   end

endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
   import mbx_pkg::*;
#(
   parameter int ADDR_W   = 10,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_sel_n,
   input  logic              a_wr_n,
   input  logic              a_oe_n,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic              b_sel_n,
   input  logic              b_wr_n,
   input  logic              b_oe_n,
   input  logic [ADDR_W-1:0] b_addr,
   output logic              a_irq_n,
   output logic              b_irq_n
);

   localparam logic [ADDR_W-1:0] BOX_HI = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] BOX_LO = {{(ADDR_W-1){1'b1}}, 1'b0};

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("mbx_irq_top: ADDR_W must be at least 2");
      end
   endgenerate

   port_ctl_t         ctl  [NUM_PORTS];
   logic [ADDR_W-1:0] addr [NUM_PORTS];
   logic [NUM_PORTS-1:0] post;
   logic [NUM_PORTS-1:0] fetch;
   logic [NUM_PORTS-1:0] flag_n;

   assign ctl[0]  = '{sel_n: a_sel_n, wr_n: a_wr_n, oe_n: a_oe_n};
   assign ctl[1]  = '{sel_n: b_sel_n, wr_n: b_wr_n, oe_n: b_oe_n};
   assign addr[0] = a_addr;
   assign addr[1] = b_addr;

   // Port 0 posts into the top word and collects from the one below; port 1 the reverse
   genvar p;
   generate
      for (p = 0; p < NUM_PORTS; p++) begin : g_port
         localparam logic [ADDR_W-1:0] OUT_A = (p == 0) ? BOX_HI : BOX_LO;
         localparam logic [ADDR_W-1:0] IN_A  = (p == 0) ? BOX_LO : BOX_HI;

         mbx_port_decode #(
            .ADDR_W  (ADDR_W),
            .OUT_ADDR(OUT_A),
            .IN_ADDR (IN_A)
         ) u_dec (
            .ctl  (ctl[p]),
            .addr (addr[p]),
            .post (post[p]),
            .fetch(fetch[p])
         );

         // Flag of port p: set by the other port's post, cleared by own fetch
         mbx_flag #(
            .SET_WINS(SET_WINS)
         ) u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (post[NUM_PORTS-1-p]),
            .clr   (fetch[p]),
            .flag_n(flag_n[p])
         );
      end
   endgenerate

   assign a_irq_n = flag_n[0];
   assign b_irq_n = flag_n[1];

endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              a_sel_n,
   input logic              a_wr_n,
   input logic              a_oe_n,
   input logic [ADDR_W-1:0] a_addr,
   input logic              b_sel_n,
   input logic              b_wr_n,
   input logic              b_oe_n,
   input logic [ADDR_W-1:0] b_addr,
   input logic              a_irq_n,
   input logic              b_irq_n
);

   localparam logic [ADDR_W-1:0] HI = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] LO = HI - 1'b1;

   logic set_b;
   logic clr_b;
   logic set_a;
   logic clr_a;

   assign set_b = !a_sel_n && !a_wr_n && (a_addr == HI);
   assign clr_b = !b_sel_n && b_wr_n && !b_oe_n && (b_addr == HI);
   assign set_a = !b_sel_n && !b_wr_n && (b_addr == LO);
   assign clr_a = !a_sel_n && a_wr_n && !a_oe_n && (a_addr == LO);

   assert_reset_high_R1: assert property (@(posedge clk)
      !rst_n |=> (a_irq_n && b_irq_n));

   assert_left_post_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set_b |=> !b_irq_n);

   assert_right_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_b && !set_b) |=> b_irq_n);

   assert_right_post_R4: assert property (@(posedge clk) disable iff (!rst_n)
      set_a |=> !a_irq_n);

   assert_left_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_a && !set_a) |=> a_irq_n);

   assert_b_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_b && !clr_b) |=> $stable(b_irq_n));

   assert_a_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_a && !clr_a) |=> $stable(a_irq_n));

endmodule

bind mbx_irq_top mbx_irq_chk #(.ADDR_W(ADDR_W)) u_mbx_irq_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .a_sel_n(a_sel_n),
   .a_wr_n (a_wr_n),
   .a_oe_n (a_oe_n),
   .a_addr (a_addr),
   .b_sel_n(b_sel_n),
   .b_wr_n (b_wr_n),
   .b_oe_n (b_oe_n),
   .b_addr (b_addr),
   .a_irq_n(a_irq_n),
   .b_irq_n(b_irq_n)
);

// File: tb/test_mbx_irq_top.sv
`timescale 1ns/1ps
module test_mbx_irq_top;

   localparam int AW = 10;
   localparam logic [AW-1:0] HI = 10'h3FF;
   localparam logic [AW-1:0] LO = 10'h3FE;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic a_sel_n = 1'b1, a_wr_n = 1'b1, a_oe_n = 1'b1;
   logic b_sel_n = 1'b1, b_wr_n = 1'b1, b_oe_n = 1'b1;
   logic [AW-1:0] a_addr = '0, b_addr = '0;
   logic a_irq_n, b_irq_n;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   mbx_irq_top #(.ADDR_W(AW)) i_mbx_irq_top (
      .clk(clk), .rst_n(rst_n),
      .a_sel_n(a_sel_n), .a_wr_n(a_wr_n), .a_oe_n(a_oe_n), .a_addr(a_addr),
      .b_sel_n(b_sel_n), .b_wr_n(b_wr_n), .b_oe_n(b_oe_n), .b_addr(b_addr),
      .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
   );

   task automatic check(input logic act, input logic exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", what, act, exp);
      end
   endtask

   // op codes: 0 idle, 1 write, 2 read, 3 write with enable high, 4 read with oe high
   task automatic set_port(input bit left, input int op, input logic [AW-1:0] ad);
      logic s, w, o;
      case (op)
         1: begin s = 0; w = 0; o = 1; end
         2: begin s = 0; w = 1; o = 0; end
         3: begin s = 1; w = 0; o = 1; end
         4: begin s = 0; w = 1; o = 1; end
         default: begin s = 1; w = 1; o = 1; end
      endcase
      if (left) begin a_sel_n = s; a_wr_n = w; a_oe_n = o; a_addr = ad; end
      else      begin b_sel_n = s; b_wr_n = w; b_oe_n = o; b_addr = ad; end
   endtask

   // Apply one cycle of accesses; on return the edge has been taken and ports are idle
   task automatic cycle(input int lop, input logic [AW-1:0] la,
                        input int rop, input logic [AW-1:0] ra);
      @(negedge clk);
      set_port(1, lop, la);
      set_port(0, rop, ra);
      @(posedge clk);
      @(negedge clk);
      set_port(1, 0, '0);
      set_port(0, 0, '0);
   endtask

   task automatic t_reset();
      rst_n = 0;
      repeat (2) @(negedge clk);
      check(a_irq_n, 1'b1, "R1 a_irq_n in reset");
      check(b_irq_n, 1'b1, "R1 b_irq_n in reset");
      rst_n = 1;
      @(negedge clk);
      check(a_irq_n, 1'b1, "R1 a_irq_n after reset");
      check(b_irq_n, 1'b1, "R1 b_irq_n after reset");
   endtask

   task automatic t_left_to_right();
      cycle(1, HI, 0, '0);
      check(b_irq_n, 1'b0, "R2 left post sets b");
      check(a_irq_n, 1'b1, "R2 left post leaves a");
      cycle(0, '0, 2, HI);
      check(b_irq_n, 1'b1, "R3 right fetch clears b");
   endtask

   task automatic t_right_to_left();
      cycle(0, '0, 1, LO);
      check(a_irq_n, 1'b0, "R4 right post sets a");
      check(b_irq_n, 1'b1, "R4 right post leaves b");
      cycle(2, LO, 0, '0);
      check(a_irq_n, 1'b1, "R5 left fetch clears a");
   endtask

   task automatic t_gating();
      cycle(3, HI, 3, LO);
      check(b_irq_n, 1'b1, "R6 left write with enable high");
      check(a_irq_n, 1'b1, "R6 right write with enable high");
      cycle(1, HI, 1, LO);
      cycle(0, '0, 4, HI);
      check(b_irq_n, 1'b0, "R6 right read with oe high");
      cycle(4, LO, 0, '0);
      check(a_irq_n, 1'b0, "R6 left read with oe high");
      cycle(3, LO, 3, HI);
      check(a_irq_n, 1'b0, "R6 disabled accesses hold a");
      check(b_irq_n, 1'b0, "R6 disabled accesses hold b");
      cycle(2, LO, 2, HI);
      check(a_irq_n, 1'b1, "R5 cleanup a");
      check(b_irq_n, 1'b1, "R3 cleanup b");
   endtask

   task automatic t_collision();
      cycle(1, HI, 2, HI);
      check(b_irq_n, 1'b0, "R7 set and clear of b together");
      cycle(2, LO, 1, LO);
      check(a_irq_n, 1'b0, "R7 set and clear of a together");
      cycle(2, LO, 2, HI);
      check(a_irq_n, 1'b1, "R5 clear after collision");
      check(b_irq_n, 1'b1, "R3 clear after collision");
   endtask

   task automatic t_other_addr();
      cycle(1, LO, 1, HI);
      check(a_irq_n, 1'b1, "R8 writes to own inbound box, a");
      check(b_irq_n, 1'b1, "R8 writes to own inbound box, b");
      cycle(1, 10'h3FD, 1, 10'h000);
      check(a_irq_n, 1'b1, "R8 writes elsewhere, a");
      check(b_irq_n, 1'b1, "R8 writes elsewhere, b");
      cycle(1, HI, 1, LO);
      cycle(2, HI, 2, LO);
      check(a_irq_n, 1'b0, "R8 read own outbound box keeps a");
      check(b_irq_n, 1'b0, "R8 read own outbound box keeps b");
      cycle(2, 10'h3FD, 2, 10'h1FF);
      check(a_irq_n, 1'b0, "R8 reads elsewhere keep a");
      check(b_irq_n, 1'b0, "R8 reads elsewhere keep b");
   endtask

   task automatic t_hold();
      repeat (5) @(negedge clk);
      check(a_irq_n, 1'b0, "R9 a held over idle");
      check(b_irq_n, 1'b0, "R9 b held over idle");
      cycle(1, HI, 1, LO);
      check(a_irq_n, 1'b0, "R9 a after repost");
      check(b_irq_n, 1'b0, "R9 b after repost");
      cycle(2, LO, 0, '0);
      check(a_irq_n, 1'b1, "R5 a cleared alone");
      check(b_irq_n, 1'b0, "R9 b unaffected by a clear");
      cycle(0, '0, 2, HI);
      check(b_irq_n, 1'b1, "R3 b cleared");
   endtask

   initial begin
      t_reset();
      t_left_to_right();
      t_right_to_left();
      t_gating();
      t_collision();
      t_other_addr();
      t_hold();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule